// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Double-Rate Memory

A small synchronous memory with two independent ports. One port only reads and the other only writes. Each port can start one operation in every main-clock cycle, and both may start in the same cycle. Every operation moves a pair of words. The first word goes to or comes from the supplied address. The second uses the partner address of the same aligned pair, so it never carries into the upper address bits.

Data moves at double rate, one word per clock phase. The design runs on a single clock at twice the main rate. A phase bit, visible as `phase_o`, marks the two halves. An edge where the phase is 0 is the main rising edge, at which commands are taken. The edge that follows is the complement edge.

Read data comes back on `rdata_o` one and a half main cycles after the read is accepted, with the second word half a cycle behind the first. `oe_o` stands in for the tri-state control: it is high only while read words are on the bus, and it drops one cycle after a slot with no read. A read issued in the same cycle as a write to the same pair returns the newly written words.

Top module: `qdr_burst2_sram`

## Requirements
- R1: While `rst_ni` is low, `oe_o` is 0, `rdata_o` is 0 and `phase_o` is 0.
- R2: `phase_o` toggles on every `clk_i` edge after reset. Commands and addresses are sampled only at edges where `phase_o` is 0. Values on `rd_n_i` and `wr_n_i` during the phase-1 half are ignored.
- R3: For a write, `wdata_i` is sampled as word 0 at the phase-0 edge that accepts the command, and as word 1 at the next edge.
- R4: Word 0 of a burst uses address A. Word 1 uses A with bit 0 inverted (A XOR 1), so an odd A pairs with A-1.
- R5: For a read accepted at edge E, word 0 appears on `rdata_o` after edge E+3 and word 1 after edge E+4.
- R6: `oe_o` is high exactly during the two words of an accepted read. It is low in the matching half-cycles after a phase-0 edge where `rd_n_i` was high.
- R7: A read and a write accepted at the same edge both complete.
- R8: A read accepted at the same edge as a write to the same pair returns the new data. Any read sees every write accepted at or before its own edge.
- R9: `rdata_o` is 0 whenever `oe_o` is low.
- R10: When `wr_n_i` is high at a phase-0 edge, the array contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; two edges per main cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_n_i | input | 1 | Read select, active low |
| rd_addr_i | input | ADDR_W | Read word address |
| wr_n_i | input | 1 | Write select, active low |
| wr_addr_i | input | ADDR_W | Write word address |
| wdata_i | input | DATA_W | Write data; word 0 then word 1 |
| rdata_o | output | DATA_W | Read data; word 0 then word 1 |
| oe_o | output | 1 | Output enable, stands in for the tri-state drive |
| phase_o | output | 1 | 0 during the half that ends at a main rising edge |

## Verification
A wrong write pipeline register or a swapped pair address shows up as a wrong word on `rdata_o`. This appears only when the affected pair is read back, at the earliest three edges after that read is accepted. A fault in read staging or phase tracking shows up sooner, as `oe_o` or word 0 arriving one edge early or late, or as the two words of a burst exchanged. The bench therefore compares every half-cycle of the output against a model of the memory, and the directed cases focus on odd addresses and same-cycle collisions.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef enum logic {
    PH_MAIN = 1'b0,
    PH_COMP = 1'b1
  } qdr_phase_e;
endpackage

// File: rtl/qdr_wr_port.sv
module qdr_wr_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  qdr_pkg::qdr_phase_e ph_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wd0_o,
  output logic [DATA_W-1:0] wd1_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      waddr_o <= '0;
      wd0_o   <= '0;
    end else if (ph_i == qdr_pkg::PH_MAIN) begin
      pend_q <= ~wr_n_i;
      if (!wr_n_i) begin
        waddr_o <= wr_addr_i;
        wd0_o   <= wdata_i;
      end
    end
  end

  // commit on the complement edge, second word taken straight from the pins
  assign we_o  = pend_q && (ph_i == qdr_pkg::PH_COMP);
  assign wd1_o = wdata_i;
endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wd0_i,
  input  logic [DATA_W-1:0] wd1_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rd0_o,
  output logic [DATA_W-1:0] rd1_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] wmate, rmate;

  assign wmate = {waddr_i[ADDR_W-1:1], ~waddr_i[0]};
  assign rmate = {raddr_i[ADDR_W-1:1], ~raddr_i[0]};

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wd0_i;
      mem_q[wmate]   <= wd1_i;
    end
  end

  assign rd0_o = mem_q[raddr_i];
  assign rd1_o = mem_q[rmate];
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  qdr_pkg::qdr_phase_e ph_i,
  input  logic              rd_n_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rd0_i,
  input  logic [DATA_W-1:0] rd1_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  logic              pend_q, buf_v_q;
  logic [DATA_W-1:0] buf0_q, buf1_q;

  // array is read one main cycle after accept, after the same-cycle write committed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      raddr_o <= '0;
      buf_v_q <= 1'b0;
      buf0_q  <= '0;
      buf1_q  <= '0;
    end else if (ph_i == qdr_pkg::PH_MAIN) begin
      pend_q  <= ~rd_n_i;
      raddr_o <= rd_addr_i;
      buf_v_q <= pend_q;
      buf0_q  <= rd0_i;
      buf1_q  <= rd1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      oe_o <= buf_v_q;
      if (!buf_v_q)                       rdata_o <= '0;
      else if (ph_i == qdr_pkg::PH_COMP)  rdata_o <= buf0_q;
      else                                rdata_o <= buf1_q;
    end
  end
endmodule

// File: rtl/qdr_burst2_sram.sv
module qdr_burst2_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_n_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic              phase_o
);
  qdr_pkg::qdr_phase_e ph_q;

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wd0, wd1, rd0, rd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= qdr_pkg::PH_MAIN;
    else         ph_q <= (ph_q == qdr_pkg::PH_MAIN) ? qdr_pkg::PH_COMP : qdr_pkg::PH_MAIN;
  end

  assign phase_o = ph_q;

  qdr_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni, .ph_i(ph_q), .wr_n_i, .wr_addr_i, .wdata_i,
    .we_o(we), .waddr_o(waddr), .wd0_o(wd0), .wd1_o(wd1)
  );

  qdr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .we_i(we), .waddr_i(waddr), .wd0_i(wd0), .wd1_i(wd1),
    .raddr_i(raddr), .rd0_o(rd0), .rd1_o(rd1)
  );

  qdr_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .ph_i(ph_q), .rd_n_i, .rd_addr_i,
    .raddr_o(raddr), .rd0_i(rd0), .rd1_i(rd1), .rdata_o, .oe_o
  );
endmodule

// File: rtl/qdr_burst2_sram_chk.sv
module qdr_burst2_sram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_n_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              oe_o,
  input logic              phase_o
);
  assert_phase_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o != $past(phase_o));

  assert_read_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_o && !rd_n_i) |-> ##4 oe_o);

  assert_nop_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_o && rd_n_i) |-> ##4 !oe_o);

  assert_oe_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !phase_o);

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> rdata_o == '0);
endmodule

bind qdr_burst2_sram qdr_burst2_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_n_i(rd_n_i),
  .rdata_o(rdata_o), .oe_o(oe_o), .phase_o(phase_o)
);

// File: tb/qdr_burst2_sram_tb.sv
module qdr_burst2_sram_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          oe, phase;

  always #2 clk = ~clk;

  qdr_burst2_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_n_i(rd_n), .rd_addr_i(rd_addr),
    .wr_n_i(wr_n), .wr_addr_i(wr_addr), .wdata_i(wdata),
    .rdata_o(rdata), .oe_o(oe), .phase_o(phase)
  );

  int checks = 0, errors = 0, slot = 0;
  logic [DW-1:0] model [DEPTH];
  logic          ev [4];
  logic [DW-1:0] e0 [4], e1 [4];
  string         et [4];

  function automatic logic [AW-1:0] mate(logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(int p, bit second);
    logic [DW-1:0] exp;
    exp = !ev[p] ? '0 : (second ? e1[p] : e0[p]);
    chk(oe == ev[p], "R6", second ? "oe word1" : "oe word0", DW'(oe), DW'(ev[p]));
    chk(rdata == exp, ev[p] ? et[p] : "R9", second ? "rdata word1" : "rdata word0", rdata, exp);
  endtask

  // one main cycle; entered at a negedge with phase 0
  task automatic run_slot(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                          logic [DW-1:0] d0, logic [DW-1:0] d1, string tag);
    int p = (slot + 2) % 4;
    int q = slot % 4;
    chk(phase == 1'b0, "R2", "phase at slot start", DW'(phase), '0);
    chk_out(p, 1'b0);
    rd_n = ~rd; rd_addr = ra; wr_n = ~wr; wr_addr = wa; wdata = d0;
    if (wr) begin
      model[wa]       = d0;
      model[mate(wa)] = d1;
    end
    ev[q] = rd; e0[q] = model[ra]; e1[q] = model[mate(ra)]; et[q] = tag;
    @(negedge clk);
    chk_out(p, 1'b1);
    // phase-1 half: selects asserted with junk addresses must be ignored (R2)
    rd_n = 1'b0; wr_n = 1'b0; rd_addr = ~ra; wr_addr = ~wa; wdata = d1;
    @(negedge clk);
    slot++;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) run_slot(1'b0, '0, 1'b0, '0, '0, '0, "R6");
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0a7c));
    for (int i = 0; i < 4; i++) begin ev[i] = 1'b0; e0[i] = '0; e1[i] = '0; et[i] = "R9"; end
    repeat (3) @(negedge clk);
    chk(oe == 1'b0, "R1", "oe in reset", DW'(oe), '0);
    chk(rdata == '0, "R1", "rdata in reset", rdata, '0);
    chk(phase == 1'b0, "R1", "phase in reset", DW'(phase), '0);
    rst_n = 1'b1;

    // prefill every pair (R3)
    for (int i = 0; i < DEPTH / 2; i++)
      run_slot(1'b0, '0, 1'b1, AW'(2 * i), DW'($urandom), DW'($urandom), "R3");

    // distinct words, read back even and odd addresses
    run_slot(1'b0, '0, 1'b1, AW'(10), 16'hA0A0, 16'hB1B1, "R3");
    run_slot(1'b1, AW'(10), 1'b0, '0, '0, '0, "R3");
    run_slot(1'b1, AW'(11), 1'b0, '0, '0, '0, "R4");
    run_slot(1'b0, '0, 1'b1, AW'(21), 16'h2121, 16'h2020, "R4");
    run_slot(1'b1, AW'(20), 1'b0, '0, '0, '0, "R4");
    nop(1);
    // same-cycle write and read, same pair
    run_slot(1'b1, AW'(30), 1'b1, AW'(30), 16'hC0DE, 16'hFACE, "R8");
    run_slot(1'b1, AW'(31), 1'b1, AW'(31), 16'h1357, 16'h2468, "R8");
    // same-cycle write and read, different pairs
    run_slot(1'b1, AW'(10), 1'b1, AW'(40), 16'h4444, 16'h5555, "R7");
    run_slot(1'b1, AW'(40), 1'b0, '0, '0, '0, "R7");
    nop(2);
    // write select high with data on the bus: nothing written
    run_slot(1'b0, '0, 1'b0, AW'(10), 16'hDEAD, 16'hBEEF, "R10");
    run_slot(1'b1, AW'(10), 1'b0, '0, '0, '0, "R10");
    // back-to-back reads then gap
    run_slot(1'b1, AW'(1), 1'b0, '0, '0, '0, "R5");
    run_slot(1'b1, AW'(2), 1'b0, '0, '0, '0, "R5");
    nop(1);
    run_slot(1'b1, AW'(3), 1'b0, '0, '0, '0, "R5");

    for (int i = 0; i < 400; i++)
      run_slot(1'($urandom), AW'($urandom), 1'($urandom), AW'($urandom),
               DW'($urandom), DW'($urandom), "R5");
    nop(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule